// File: doc/BRIEF.md
# Parallel Flash Configuration Loader

This block runs once after reset. It fetches a twelve-byte configuration record from the highest addresses of a byte-wide parallel flash. It checks three signature bytes and reads one speed byte. If the signatures match, it copies eight identification bytes into configuration registers. The read starts at the top address, and each later byte sits one address lower.

Every flash read holds its address for a fixed number of clock cycles. That count comes from the access time of the flash part, rounded up to whole clocks. The first reads use the slow (240 ns) count. The speed byte can switch the rest of the record to the fast (120 ns) count. While the load is running, the busy flag stays high so that other logic can answer host accesses with a retry. Done marks the point where any later initialisation step, such as a serial EEPROM load, may begin.

Top module: `cfg_flash_loader`

## Requirements
- R1: While reset is asserted and on release, busy is 1, done is 0 and valid is 0. The four field outputs hold their parameter defaults, and chip select and output enable are high (inactive).
- R2: Record byte k (k = 0..11) is read from address TOP−k, where TOP is the all-ones address. The address only ever steps down by one, and no address outside TOP−11..TOP is driven while chip select is low.
- R3: Bytes 0, 1 and 2 each hold their address, with chip select and output enable low, for SLOW_WAIT = ceil(240 ns / clock period) cycles.
- R4: Bytes 3 to 11 each hold for FAST_WAIT = ceil(120 ns / clock period) cycles if byte 2 read 0xAA. For any other byte 2 value they hold for SLOW_WAIT cycles.
- R5: Byte 0 must be 0xAA, byte 1 must be 0x55 and byte 3 must be 0x55. On the first mismatch, no further byte is read, done goes to 1, valid stays 0 and all field outputs keep their defaults.
- R6: In a valid record, byte 4 and byte 5 land in dev_id_hi[7:0] and [15:8] (device ID bits 23:16 and 31:24). Bytes 6 and 7 land in class_hi[7:0] and [15:8] (class code bits 15:8 and 23:16). Bytes 8 and 9 land in subsys_vid[7:0] and [15:8]. Bytes 10 and 11 land in subsys_id_hi[7:0] and [15:8] (subsystem ID bits 23:16 and 31:24).
- R7: In the same cycle that chip select returns high after the final read, done is 1. After byte 11 of a valid record, valid is 1. From then on, chip select and output enable stay high and every output holds its value until the next reset.
- R8: Busy is 1 exactly while done is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronised internally for release |
| flash_data | input | 8 | Flash read data |
| flash_addr | output | ADDR_W | Flash byte address |
| flash_ce_n | output | 1 | Flash chip select, active low |
| flash_oe_n | output | 1 | Flash output enable, active low |
| dev_id_hi | output | 16 | Device ID bits 31:16 |
| class_hi | output | 16 | Class code bits 23:8 |
| subsys_vid | output | 16 | Subsystem vendor ID |
| subsys_id_hi | output | 16 | Subsystem ID bits 31:16 |
| cfg_valid | output | 1 | Record accepted and fields loaded |
| load_done | output | 1 | Load sequence finished |
| load_busy | output | 1 | Load sequence in progress |

## Verification
On every cycle, the assertions check these properties:
- the address only ever steps downward, and stays inside the record window;
- no address is held longer than the slow wait count;
- the bus is idle once the load is done;
- busy is the inverse of done;
- the outputs are frozen after completion;
- a rejected record leaves the defaults in place.

Other behaviour can only be shown by the bench's scenarios. These cover the exact per-byte hold lengths, including the switch to fast timing after the speed byte, and the byte-to-field mapping. They also cover the point at which a bad signature stops the read, for each of the three signature positions.

// File: rtl/cfl_pkg.sv
package cfl_pkg;
  typedef enum logic [1:0] {
    CFL_IDLE = 2'd0,
    CFL_READ = 2'd1,
    CFL_DONE = 2'd2
  } cfl_state_e;

  localparam int REC_BYTES   = 12;
  localparam int IDX_W       = 4;
  localparam int FIELD_BASE  = 4;
  localparam int FIELD_LANES = 8;
  localparam int LANE_W      = 3;

  localparam int IDX_SIG0  = 0;
  localparam int IDX_SIG1  = 1;
  localparam int IDX_SPEED = 2;
  localparam int IDX_SIG2  = 3;

  localparam logic [7:0] SIG_HI     = 8'hAA;
  localparam logic [7:0] SIG_LO     = 8'h55;
  localparam logic [7:0] SPEED_FAST = 8'hAA;

  // Whole cycles needed to cover an access time, never less than one.
  function automatic int ns_to_cycles(input int ns, input int period_ns);
    int c;
    c = (ns + period_ns - 1) / period_ns;
    return (c < 1) ? 1 : c;
  endfunction
endpackage

// File: rtl/cfl_rst_sync.sv
module cfl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= {sr_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sr_q[STAGES-1];
endmodule

// File: rtl/cfl_wait_timer.sv
module cfl_wait_timer #(
  parameter int SLOW_WAIT = 24,
  parameter int FAST_WAIT = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic reload_fast,
  output logic expire
);
  localparam int MAX_WAIT = (SLOW_WAIT > FAST_WAIT) ? SLOW_WAIT : FAST_WAIT;
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);
  localparam logic [CNT_W-1:0] SLOW_LD = CNT_W'(SLOW_WAIT - 1);
  localparam logic [CNT_W-1:0] FAST_LD = CNT_W'(FAST_WAIT - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign expire = run && (cnt_q == '0);
  assign cnt_en = run;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_q == '0) cnt_d = reload_fast ? FAST_LD : SLOW_LD;
    else             cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= SLOW_LD;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cfl_field_regs.sv
module cfl_field_regs
  import cfl_pkg::*;
#(
  parameter logic [8*FIELD_LANES-1:0] DFLT_FIELDS = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ld_en,
  input  logic [LANE_W-1:0]        ld_lane,
  input  logic [7:0]               ld_data,
  output logic [8*FIELD_LANES-1:0] fields
);
  for (genvar g = 0; g < FIELD_LANES; g++) begin : g_lane
    logic [7:0] lane_q;
    logic       lane_en;

    assign lane_en = ld_en && (ld_lane == LANE_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       lane_q <= DFLT_FIELDS[8*g +: 8];
      else if (lane_en) lane_q <= ld_data;
    end

    assign fields[8*g +: 8] = lane_q;
  end
endmodule

// File: rtl/cfl_seq.sv
module cfl_seq
  import cfl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        flash_data,
  input  logic              expire,
  output logic              run,
  output logic              reload_fast,
  output logic              bus_active,
  output logic [IDX_W-1:0]  idx,
  output logic              ld_en,
  output logic [LANE_W-1:0] ld_lane,
  output logic              done,
  output logic              valid,
  output logic              busy
);
  cfl_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             fast_q, fast_d;
  logic             done_q, done_d;
  logic             valid_q, valid_d;
  logic             busy_q, busy_d;
  logic             sample, last_byte, sig_bad, finish;
  logic [IDX_W-1:0] rel_idx;

  assign run        = (state_q == CFL_READ);
  assign bus_active = (state_q == CFL_READ);
  assign sample     = run && expire;
  assign last_byte  = (idx_q == IDX_W'(REC_BYTES - 1));

  always_comb begin
    sig_bad = 1'b0;
    if (idx_q == IDX_W'(IDX_SIG0) && flash_data != SIG_HI) sig_bad = 1'b1;
    if (idx_q == IDX_W'(IDX_SIG1) && flash_data != SIG_LO) sig_bad = 1'b1;
    if (idx_q == IDX_W'(IDX_SIG2) && flash_data != SIG_LO) sig_bad = 1'b1;
  end

  assign finish = sample && (sig_bad || last_byte);

  // Speed choice takes effect for the byte after the speed byte.
  assign fast_d = fast_q ||
                  (sample && idx_q == IDX_W'(IDX_SPEED) && flash_data == SPEED_FAST);
  assign reload_fast = fast_d;

  assign rel_idx = idx_q - IDX_W'(FIELD_BASE);
  assign ld_en   = sample && (idx_q >= IDX_W'(FIELD_BASE));
  assign ld_lane = rel_idx[LANE_W-1:0];

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    done_d  = done_q;
    valid_d = valid_q;
    busy_d  = busy_q;
    unique case (state_q)
      CFL_IDLE: state_d = CFL_READ;
      CFL_READ: begin
        if (finish) begin
          state_d = CFL_DONE;
          done_d  = 1'b1;
          busy_d  = 1'b0;
          valid_d = !sig_bad;
        end else if (sample) begin
          idx_d = idx_q + 1'b1;
        end
      end
      CFL_DONE: state_d = CFL_DONE;
      default:  state_d = CFL_DONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CFL_IDLE;
      idx_q   <= '0;
      fast_q  <= 1'b0;
      done_q  <= 1'b0;
      valid_q <= 1'b0;
      busy_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      done_q  <= done_d;
      valid_q <= valid_d;
      busy_q  <= busy_d;
      if (sample) fast_q <= fast_d;
    end
  end

  assign idx   = idx_q;
  assign done  = done_q;
  assign valid = valid_q;
  assign busy  = busy_q;
endmodule

// File: rtl/cfg_flash_loader.sv
module cfg_flash_loader
  import cfl_pkg::*;
#(
  parameter int          ADDR_W     = 19,
  parameter int          CLK_NS     = 10,
  parameter int          SLOW_NS    = 240,
  parameter int          FAST_NS    = 120,
  parameter int          SYNC_STAGES = 2,
  parameter logic [15:0] DEV_DFLT   = 16'hA5C3,
  parameter logic [15:0] CLS_DFLT   = 16'h0101,
  parameter logic [15:0] SVID_DFLT  = 16'h1B2D,
  parameter logic [15:0] SSID_DFLT  = 16'h7E81
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        flash_data,
  output logic [ADDR_W-1:0] flash_addr,
  output logic              flash_ce_n,
  output logic              flash_oe_n,
  output logic [15:0]       dev_id_hi,
  output logic [15:0]       class_hi,
  output logic [15:0]       subsys_vid,
  output logic [15:0]       subsys_id_hi,
  output logic              cfg_valid,
  output logic              load_done,
  output logic              load_busy
);
  localparam int SLOW_WAIT = ns_to_cycles(SLOW_NS, CLK_NS);
  localparam int FAST_WAIT = ns_to_cycles(FAST_NS, CLK_NS);
  localparam logic [ADDR_W-1:0] TOP_ADDR = '1;
  localparam logic [8*FIELD_LANES-1:0] DFLT_FIELDS =
    {SSID_DFLT, SVID_DFLT, CLS_DFLT, DEV_DFLT};

  logic                     rst_sync_n;
  logic                     run, reload_fast, expire, bus_active;
  logic [IDX_W-1:0]         idx;
  logic                     ld_en;
  logic [LANE_W-1:0]        ld_lane;
  logic [8*FIELD_LANES-1:0] fields;

  cfl_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cfl_wait_timer #(.SLOW_WAIT(SLOW_WAIT), .FAST_WAIT(FAST_WAIT)) u_timer (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .run         (run),
    .reload_fast (reload_fast),
    .expire      (expire)
  );

  cfl_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .flash_data  (flash_data),
    .expire      (expire),
    .run         (run),
    .reload_fast (reload_fast),
    .bus_active  (bus_active),
    .idx         (idx),
    .ld_en       (ld_en),
    .ld_lane     (ld_lane),
    .done        (load_done),
    .valid       (cfg_valid),
    .busy        (load_busy)
  );

  cfl_field_regs #(.DFLT_FIELDS(DFLT_FIELDS)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .ld_en   (ld_en),
    .ld_lane (ld_lane),
    .ld_data (flash_data),
    .fields  (fields)
  );

  assign flash_addr   = TOP_ADDR - ADDR_W'(idx);
  assign flash_ce_n   = !bus_active;
  assign flash_oe_n   = !bus_active;
  assign dev_id_hi    = fields[15:0];
  assign class_hi     = fields[31:16];
  assign subsys_vid   = fields[47:32];
  assign subsys_id_hi = fields[63:48];
endmodule

// File: rtl/cfl_checker.sv
module cfl_checker #(
  parameter int          ADDR_W      = 19,
  parameter int          SLOW_WAIT   = 24,
  parameter logic [63:0] DFLT_FIELDS = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] flash_addr,
  input logic              flash_ce_n,
  input logic              flash_oe_n,
  input logic [63:0]       fields,
  input logic              cfg_valid,
  input logic              load_done,
  input logic              load_busy
);
  localparam logic [ADDR_W-1:0] TOP_ADDR = '1;
  localparam logic [ADDR_W-1:0] LOW_ADDR = TOP_ADDR - ADDR_W'(11);

  logic [15:0]       hold_q;
  logic [ADDR_W-1:0] prev_addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q      <= '0;
      prev_addr_q <= '0;
    end else begin
      prev_addr_q <= flash_addr;
      if (flash_ce_n)                      hold_q <= '0;
      else if (flash_addr != prev_addr_q)  hold_q <= 16'd1;
      else                                 hold_q <= hold_q + 16'd1;
    end
  end

  // R3: no address held beyond the slow access count
  a_r3_hold_max: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q <= 16'(SLOW_WAIT));

  // R2: addresses step down by one
  a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!flash_ce_n && $past(!flash_ce_n) && flash_addr != $past(flash_addr))
      |-> flash_addr == $past(flash_addr) - ADDR_W'(1));

  // R2: record window only
  a_r2_window: assert property (@(posedge clk) disable iff (!rst_n)
    !flash_ce_n |-> flash_addr >= LOW_ADDR);

  // R5: rejected record keeps defaults
  a_r5_defaults: assert property (@(posedge clk) disable iff (!rst_n)
    (load_done && !cfg_valid) |-> fields == DFLT_FIELDS);

  // R7: bus idle once finished
  a_r7_bus_idle: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |-> (flash_ce_n && flash_oe_n));

  // R7: outputs frozen after completion
  a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> (load_done && $stable(fields) && $stable(cfg_valid)));

  // R7: valid only with done
  a_r7_valid_done: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> load_done);

  // R8: busy is the complement of done
  a_r8_busy: assert property (@(posedge clk) disable iff (!rst_n)
    load_busy == !load_done);
endmodule

bind cfg_flash_loader cfl_checker #(
  .ADDR_W      (ADDR_W),
  .SLOW_WAIT   (SLOW_WAIT),
  .DFLT_FIELDS (DFLT_FIELDS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .flash_addr (flash_addr),
  .flash_ce_n (flash_ce_n),
  .flash_oe_n (flash_oe_n),
  .fields     (fields),
  .cfg_valid  (cfg_valid),
  .load_done  (load_done),
  .load_busy  (load_busy)
);

// File: tb/cfg_flash_loader_tb.sv
module cfg_flash_loader_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 19;
  localparam int SLOW_W     = (240 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int FAST_W     = (120 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam logic [ADDR_W-1:0] TOP = '1;
  localparam logic [15:0] D_DEV = 16'hA5C3, D_CLS = 16'h0101,
                          D_SVID = 16'h1B2D, D_SSID = 16'h7E81;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [7:0]        flash_data;
  logic [ADDR_W-1:0] flash_addr;
  logic              flash_ce_n, flash_oe_n;
  logic [15:0]       dev_id_hi, class_hi, subsys_vid, subsys_id_hi;
  logic              cfg_valid, load_done, load_busy;

  int checks = 0;
  int fails  = 0;
  logic [7:0] img [12];
  int hold [12];
  int stray, gap, busy_bad;
  bit seen;
  logic [ADDR_W-1:0] last_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_flash_loader #(.ADDR_W(ADDR_W), .CLK_NS(CLK_PERIOD)) u_dut (
    .clk(clk), .rst_n(rst_n), .flash_data(flash_data),
    .flash_addr(flash_addr), .flash_ce_n(flash_ce_n), .flash_oe_n(flash_oe_n),
    .dev_id_hi(dev_id_hi), .class_hi(class_hi), .subsys_vid(subsys_vid),
    .subsys_id_hi(subsys_id_hi), .cfg_valid(cfg_valid),
    .load_done(load_done), .load_busy(load_busy)
  );

  // Flash model: record at top, erased bytes elsewhere
  always_comb begin
    if (flash_addr >= TOP - ADDR_W'(11)) flash_data = img[int'(TOP - flash_addr)];
    else                                 flash_data = 8'hFF;
  end

  // Bus monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (!flash_ce_n) begin
        if (flash_oe_n) stray++;
        if (seen && flash_addr > last_addr) stray++;
        if (flash_addr >= TOP - ADDR_W'(11)) hold[int'(TOP - flash_addr)]++;
        else stray++;
        seen = 1'b1;
        last_addr = flash_addr;
        if (!load_busy || load_done) busy_bad++;
      end else if (seen && !load_done) gap++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic start(input logic [7:0] b [12]);
    rst_n = 1'b0;
    for (int i = 0; i < 12; i++) begin img[i] = b[i]; hold[i] = 0; end
    stray = 0; gap = 0; busy_bad = 0; seen = 1'b0; last_addr = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_and_check(input logic [7:0] b [12]);
    int exp_hold [12];
    bit fast, ok_sig, stop;
    logic [15:0] e_dev, e_cls, e_svid, e_ssid;
    int n;
    fast = 0; stop = 0; ok_sig = 1;
    for (int i = 0; i < 12; i++) begin
      exp_hold[i] = stop ? 0 : (fast ? FAST_W : SLOW_W);
      if (!stop) begin
        if ((i == 0 && b[i] != 8'hAA) || ((i == 1 || i == 3) && b[i] != 8'h55)) begin
          stop = 1; ok_sig = 0;
        end
        if (i == 2 && b[i] == 8'hAA) fast = 1;
      end
    end
    e_dev  = ok_sig ? {b[5], b[4]}   : D_DEV;
    e_cls  = ok_sig ? {b[7], b[6]}   : D_CLS;
    e_svid = ok_sig ? {b[9], b[8]}   : D_SVID;
    e_ssid = ok_sig ? {b[11], b[10]} : D_SSID;
    start(b);
    n = 0;
    while (!load_done && n < 2000) begin @(negedge clk); n++; end
    chk(load_done == 1'b1, "R7", "done reached", 64'(load_done), 64'd1);
    for (int i = 0; i < 3; i++)
      chk(hold[i] == exp_hold[i], "R3", $sformatf("hold byte %0d", i),
          64'(hold[i]), 64'(exp_hold[i]));
    for (int i = 3; i < 12; i++)
      chk(hold[i] == exp_hold[i], ok_sig ? "R4" : "R5",
          $sformatf("hold byte %0d", i), 64'(hold[i]), 64'(exp_hold[i]));
    chk(stray == 0, "R2", "address order/window", 64'(stray), 64'd0);
    chk(gap == 0, "R7", "idle gap before done", 64'(gap), 64'd0);
    chk(busy_bad == 0, "R8", "busy during reads", 64'(busy_bad), 64'd0);
    chk(cfg_valid == ok_sig, ok_sig ? "R7" : "R5", "valid",
        64'(cfg_valid), 64'(ok_sig));
    chk(load_busy == 1'b0, "R8", "busy after done", 64'(load_busy), 64'd0);
    chk(dev_id_hi == e_dev, "R6", "dev_id_hi", 64'(dev_id_hi), 64'(e_dev));
    chk(class_hi == e_cls, "R6", "class_hi", 64'(class_hi), 64'(e_cls));
    chk(subsys_vid == e_svid, "R6", "subsys_vid", 64'(subsys_vid), 64'(e_svid));
    chk(subsys_id_hi == e_ssid, "R6", "subsys_id_hi", 64'(subsys_id_hi), 64'(e_ssid));
    repeat (30) @(negedge clk);
    chk(flash_ce_n && flash_oe_n, "R7", "bus idle after done",
        64'({flash_ce_n, flash_oe_n}), 64'd3);
    chk(load_done && cfg_valid == ok_sig && dev_id_hi == e_dev && subsys_id_hi == e_ssid,
        "R7", "outputs held", 64'({load_done, cfg_valid}), 64'({1'b1, ok_sig}));
  endtask

  task automatic t_reset;
    logic [7:0] b [12] = '{8'hAA, 8'h55, 8'hAA, 8'h55, 8'h11, 8'h22,
                           8'h33, 8'h44, 8'h55, 8'h66, 8'h77, 8'h88};
    rst_n = 1'b0;
    for (int i = 0; i < 12; i++) img[i] = b[i];
    repeat (4) @(negedge clk);
    chk(load_busy && !load_done && !cfg_valid, "R1", "flags in reset",
        64'({load_busy, load_done, cfg_valid}), 64'b100);
    chk(flash_ce_n && flash_oe_n, "R1", "bus idle in reset",
        64'({flash_ce_n, flash_oe_n}), 64'd3);
    chk({subsys_id_hi, subsys_vid, class_hi, dev_id_hi} ==
        {D_SSID, D_SVID, D_CLS, D_DEV}, "R1", "field defaults",
        {subsys_id_hi, subsys_vid, class_hi, dev_id_hi}, {D_SSID, D_SVID, D_CLS, D_DEV});
    rst_n = 1'b1;
    @(negedge clk);
    chk(load_busy && !load_done && !cfg_valid, "R1", "flags at release",
        64'({load_busy, load_done, cfg_valid}), 64'b100);
  endtask

  task automatic t_fast_valid;
    logic [7:0] b [12] = '{8'hAA, 8'h55, 8'hAA, 8'h55, 8'h80, 8'h06,
                           8'h85, 8'h01, 8'h95, 8'h10, 8'h01, 8'hC0};
    run_and_check(b);
  endtask

  task automatic t_slow_valid;
    logic [7:0] b [12] = '{8'hAA, 8'h55, 8'h3C, 8'h55, 8'hDE, 8'hAD,
                           8'hBE, 8'hEF, 8'h12, 8'h34, 8'h56, 8'h78};
    run_and_check(b);
  endtask

  task automatic t_bad_sig0;
    logic [7:0] b [12] = '{8'hAB, 8'h55, 8'hAA, 8'h55, 8'h01, 8'h02,
                           8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08};
    run_and_check(b);
  endtask

  task automatic t_bad_sig1;
    logic [7:0] b [12] = '{8'hAA, 8'hAA, 8'hAA, 8'h55, 8'h01, 8'h02,
                           8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08};
    run_and_check(b);
  endtask

  task automatic t_bad_sig3;
    logic [7:0] b [12] = '{8'hAA, 8'h55, 8'hAA, 8'h54, 8'h01, 8'h02,
                           8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08};
    run_and_check(b);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL R7 watchdog expired: actual running expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_fast_valid();
    t_slow_valid();
    t_bad_sig0();
    t_bad_sig1();
    t_bad_sig3();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule